// File: doc/BRIEF.md
# I2C EEPROM Target Controller

This block is the bus-facing logic of a 2048-byte serial memory that answers as a target on an I2C bus. Both bus lines are brought into the core clock domain, cleaned of short pulses, and watched for START and STOP conditions. The block checks the device code in the first byte of each transfer and takes the top three address bits from that byte. It then takes a word-address byte for the low eight bits and either accepts write data or returns read data.

Write data is collected in a 16-byte page buffer and copied into the array only after the transfer ends with STOP. The copy happens during a busy period of a parameterised number of clocks. While that period runs, the block does not answer its device code. A write-lock input, or a supply-OK input that is low, cancels the copy. SDA is open-drain, so the block only requests a low level through a pull output.

Top module: `serial_mem_target`

## Requirements
- R1: After reset the pull output is 0 (SDA released) and the block waits for a START.
- R2: A first byte whose upper four bits are 1010 is acknowledged. Any other first byte gets no acknowledge, and the block ignores every later byte until the next START.
- R3: Bits 3..1 of the first byte are address bits 10..8 and bit 0 selects read (1) or write (0). In a write, the next byte gives address bits 7..0. A byte written this way and read back with a random read returns the written value.
- R4: In a page write, each data byte goes to the current address, and only the low four address bits then advance, wrapping inside the same 16-byte page.
- R5: The array is written only after a STOP that ends a write holding at least one data byte. For BUSY_CYC clocks after that STOP, the block does not acknowledge its device code.
- R6: If the write-lock input is high at STOP, data bytes are still acknowledged but the array is unchanged and no busy period starts.
- R7: If the supply-OK input is low at STOP, the array is unchanged and no busy period starts.
- R8: Sequential reads advance the full 11-bit address, wrapping from 0x7FF to 0x000. A master acknowledge (SDA low) asks for the next byte, and a not-acknowledge ends the read.
- R9: A read with no word address (a current-address read) returns the byte after the last one read, with address bits 10..8 taken from the first byte.
- R10: A pulse on SCL or SDA shorter than FILT_LEN clocks has no effect on the protocol.
- R11: The pull output only becomes active while SCL is low, so the block never makes a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| wr_lock_i | input | 1 | High makes the whole array read-only |
| supply_ok_i | input | 1 | High when the supply is above the reset threshold |
| sda_pull_o | output | 1 | 1 requests SDA to be pulled low, 0 releases it |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except when it makes a START or STOP. They also assume that the master never makes a START or STOP while the block is driving a data or acknowledge bit low. The lock and supply inputs are taken to be steady around each STOP. The bench master changes SDA a quarter period after each SCL fall, holds SCL high for half a period, and changes lock and supply only between transfers. Its only deliberate break of these timing rules is one sub-filter pulse on SDA while SCL is high, which tests glitch rejection.

// File: rtl/smt_pkg.sv
package smt_pkg;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WADR,
        ST_WDAT,
        ST_ACK,
        ST_RDAT,
        ST_RACK
    } state_t;
endpackage

// File: rtl/smt_glitch_filt.sv
module smt_glitch_filt #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic line_o
);
    localparam int CW = $clog2(LEN + 1);

    typedef struct packed {
        logic [1:0]    sy;
        logic [CW-1:0] cnt;
        logic          out;
    } filt_s;

    filt_s q, d;

    always_comb begin
        d = q;
        d.sy = {q.sy[0], raw_i};
        if (q.sy[1] != q.out) begin
            if (q.cnt == CW'(LEN - 1)) begin
                d.out = q.sy[1];
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.sy  <= 2'b11;
            q.out <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign line_o = q.out;

    AST_FILT_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.out) |-> ($past(q.sy[1], 2) == q.out)); // R10
endmodule

// File: rtl/smt_store.sv
module smt_store #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [7:0]        rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/smt_bus_fsm.sv
module smt_bus_fsm
    import smt_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int PAGE     = 16,
    parameter int BUSY_CYC = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              wr_lock_i,
    input  logic              supply_ok_i,
    input  logic [7:0]        rd_data_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_waddr_o,
    output logic [7:0]        mem_wdata_o,
    output logic [ADDR_W-1:0] mem_raddr_o,
    output logic              sda_pull_o
);
    localparam int PB   = $clog2(PAGE);
    localparam int HI_W = ADDR_W - 8;
    localparam int BW   = $clog2(BUSY_CYC + 1);

    typedef struct packed {
        state_t                st;
        state_t                nxt;
        logic [3:0]            bc;
        logic [7:0]            sh;
        logic [ADDR_W-1:0]     ptr;
        logic                  cont;
        logic                  pull;
        logic                  scl_p;
        logic                  sda_p;
        logic [PAGE-1:0][7:0]  pbuf;
        logic [PAGE-1:0]       vld;
        logic [BW-1:0]         busy;
        logic [PB:0]           ci;
    } fsm_s;

    fsm_s q, d;
    logic rise, fall, start, stop, busy;

    always_comb begin
        d       = q;
        d.scl_p = scl_i;
        d.sda_p = sda_i;
        rise    = scl_i & ~q.scl_p;
        fall    = ~scl_i & q.scl_p;
        start   = scl_i & q.scl_p & q.sda_p & ~sda_i;
        stop    = scl_i & q.scl_p & ~q.sda_p & sda_i;
        busy    = (q.busy != '0);

        if (busy) begin
            d.busy = q.busy - 1'b1;
            if (!q.ci[PB]) d.ci = q.ci + 1'b1;
        end

        if (start) begin
            if (!busy) begin
                d.st   = ST_DEV;
                d.bc   = '0;
                d.pull = 1'b0;
                d.vld  = '0;
            end
        end else if (stop) begin
            if (q.st == ST_WDAT && |q.vld && !wr_lock_i && supply_ok_i && !busy) begin
                d.busy = BW'(BUSY_CYC);
                d.ci   = '0;
            end
            d.st   = ST_IDLE;
            d.pull = 1'b0;
        end else begin
            case (q.st)
                ST_DEV, ST_WADR, ST_WDAT: begin
                    if (rise) begin
                        d.sh = {q.sh[6:0], sda_i};
                        d.bc = q.bc + 1'b1;
                    end else if (fall && q.bc == 4'd8) begin
                        d.bc   = '0;
                        d.pull = 1'b1;
                        d.st   = ST_ACK;
                        if (q.st == ST_DEV) begin
                            if (q.sh[7:4] == DEV_CODE) begin
                                d.ptr[ADDR_W-1:8] = q.sh[HI_W:1];
                                d.nxt = q.sh[0] ? ST_RDAT : ST_WADR;
                            end else begin
                                d.st   = ST_IDLE;
                                d.pull = 1'b0;
                            end
                        end else if (q.st == ST_WADR) begin
                            d.ptr[7:0] = q.sh;
                            d.nxt      = ST_WDAT;
                        end else begin
                            d.pbuf[q.ptr[PB-1:0]] = q.sh;
                            d.vld[q.ptr[PB-1:0]]  = 1'b1;
                            d.ptr[PB-1:0]         = q.ptr[PB-1:0] + 1'b1;
                            d.nxt                 = ST_WDAT;
                        end
                    end
                end
                ST_ACK: begin
                    if (fall) begin
                        d.st = q.nxt;
                        d.bc = '0;
                        if (q.nxt == ST_RDAT) begin
                            d.sh   = rd_data_i;
                            d.ptr  = q.ptr + 1'b1;
                            d.pull = ~rd_data_i[7];
                        end else begin
                            d.pull = 1'b0;
                        end
                    end
                end
                ST_RDAT: begin
                    if (rise) begin
                        d.bc = q.bc + 1'b1;
                    end else if (fall) begin
                        if (q.bc == 4'd8) begin
                            d.pull = 1'b0;
                            d.st   = ST_RACK;
                        end else begin
                            d.sh   = {q.sh[6:0], 1'b0};
                            d.pull = ~q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (rise) begin
                        d.cont = ~sda_i;
                    end else if (fall) begin
                        if (q.cont) begin
                            d.sh   = rd_data_i;
                            d.ptr  = q.ptr + 1'b1;
                            d.pull = ~rd_data_i[7];
                            d.bc   = '0;
                            d.st   = ST_RDAT;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.nxt   <= ST_IDLE;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign mem_we_o    = (q.busy != '0) && !q.ci[PB] && q.vld[q.ci[PB-1:0]];
    assign mem_waddr_o = {q.ptr[ADDR_W-1:PB], q.ci[PB-1:0]};
    assign mem_wdata_o = q.pbuf[q.ci[PB-1:0]];
    assign mem_raddr_o = q.ptr;
    assign sda_pull_o  = q.pull;

    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy != '0) |-> !q.pull); // R5
    AST_LOCK_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy != '0) |-> !$past(wr_lock_i)); // R6
    AST_SUPPLY_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy != '0) |-> $past(supply_ok_i)); // R7
    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ACK && q.nxt == ST_WDAT) |=>
        (q.ptr[ADDR_W-1:PB] == $past(q.ptr[ADDR_W-1:PB]))); // R4
    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.pull) |-> !scl_i); // R11
endmodule

// File: rtl/serial_mem_target.sv
module serial_mem_target #(
    parameter int ADDR_W   = 11,
    parameter int PAGE     = 16,
    parameter int FILT_LEN = 8,
    parameter int BUSY_CYC = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wr_lock_i,
    input  logic supply_ok_i,
    output logic sda_pull_o
);
    logic [1:0]        raw, filt;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr;
    logic [7:0]        mem_wdata, mem_rdata;

    assign raw = {sda_i, scl_i};

    for (genvar i = 0; i < 2; i++) begin : g_filt
        smt_glitch_filt #(.LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw[i]),
            .line_o (filt[i])
        );
    end

    smt_bus_fsm #(.ADDR_W(ADDR_W), .PAGE(PAGE), .BUSY_CYC(BUSY_CYC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (filt[0]),
        .sda_i       (filt[1]),
        .wr_lock_i   (wr_lock_i),
        .supply_ok_i (supply_ok_i),
        .rd_data_i   (mem_rdata),
        .mem_we_o    (mem_we),
        .mem_waddr_o (mem_waddr),
        .mem_wdata_o (mem_wdata),
        .mem_raddr_o (mem_raddr),
        .sda_pull_o  (sda_pull_o)
    );

    smt_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (mem_wdata),
        .raddr_i (mem_raddr),
        .rdata_o (mem_rdata)
    );
endmodule

// File: tb/sim_serial_mem_target.sv
module sim_serial_mem_target;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 25;
    localparam int BUSY       = 3000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mscl = 1'b1, msda = 1'b1;
    logic wr_lock = 1'b0, supply_ok = 1'b1;
    logic pull, bus_sda;

    int n_chk = 0, n_fail = 0, viol = 0, hi_cnt = 0;
    int exp_mem [2048];
    logic pull_prev = 1'b0;

    assign bus_sda = msda & ~pull;

    serial_mem_target #(.BUSY_CYC(BUSY)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (mscl),
        .sda_i       (bus_sda),
        .wr_lock_i   (wr_lock),
        .supply_ok_i (supply_ok),
        .sda_pull_o  (pull)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // R11 monitor: pull must not change during a settled SCL-high phase
    always @(negedge clk) begin
        if (mscl) hi_cnt++; else hi_cnt = 0;
        if (hi_cnt > 12 && pull !== pull_prev) viol++;
        pull_prev = pull;
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart;
        wc(Q); msda = 1'b1; wc(Q); mscl = 1'b1; wc(2 * Q); msda = 1'b0; wc(2 * Q); mscl = 1'b0;
    endtask

    task automatic bstop;
        wc(Q); msda = 1'b0; wc(Q); mscl = 1'b1; wc(2 * Q); msda = 1'b1; wc(2 * Q);
    endtask

    task automatic sbit(logic b, logic gl);
        wc(Q); msda = b; wc(Q); mscl = 1'b1;
        if (gl) begin
            wc(Q / 2); msda = 1'b0; wc(3); msda = 1'b1; wc(2 * Q - Q / 2 - 3);
        end else begin
            wc(2 * Q);
        end
        mscl = 1'b0;
    endtask

    task automatic send(logic [7:0] b, logic gl, output logic ack);
        for (int i = 7; i >= 0; i--) sbit(b[i], gl && i == 7);
        wc(Q); msda = 1'b1; wc(Q); mscl = 1'b1; wc(Q);
        ack = (bus_sda == 1'b0);
        wc(Q); mscl = 1'b0;
    endtask

    task automatic recv(logic mack, output logic [7:0] v);
        msda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wc(2 * Q); mscl = 1'b1; wc(Q); v[i] = bus_sda; wc(Q); mscl = 1'b0;
        end
        sbit(!mack, 1'b0);
    endtask

    function automatic logic [7:0] devb(int a, logic rd);
        return {4'b1010, a[10:8], rd};
    endfunction

    // behavioural model: page-wrapped write applied only when lock is low and supply is good
    task automatic wr_txn(int a, logic [7:0] data [$], logic gl, string req);
        logic k;
        bstart;
        send(devb(a, 1'b0), 1'b0, k); chk("R2 device code ack", k, 1);
        send(a[7:0], 1'b0, k);        chk("R3 word address ack", k, 1);
        foreach (data[i]) begin
            send(data[i], gl && i == 0, k);
            chk({req, " data ack"}, k, 1);
            if (!wr_lock && supply_ok)
                exp_mem[{a[10:4], 4'(a[3:0] + i)}] = data[i];
        end
        bstop;
    endtask

    task automatic rd_seq(int a, int n, string req);
        logic k;
        logic [7:0] v;
        bstart;
        send(devb(a, 1'b0), 1'b0, k);
        send(a[7:0], 1'b0, k);
        bstart;
        send(devb(a, 1'b1), 1'b0, k); chk({req, " read device ack"}, k, 1);
        for (int i = 0; i < n; i++) begin
            recv(i < n - 1, v);
            chk(req, v, exp_mem[(a + i) % 2048]);
        end
        bstop;
    endtask

    task automatic run_all;
        logic k;
        logic [7:0] v;
        wc(5); rst_n = 1'b1; wc(5);
        chk("R1 reset releases SDA", pull, 0);

        // R2: foreign device code and the byte after it are not acknowledged
        bstart;
        send(8'h90, 1'b0, k); chk("R2 foreign code nack", k, 0);
        send(8'h00, 1'b0, k); chk("R2 ignored after nack", k, 0);
        bstop;

        // R3 byte write, R5 busy window
        wr_txn(11'h5F3, '{8'hA7}, 1'b0, "R3");
        bstart;
        send(devb(11'h5F3, 1'b0), 1'b0, k); chk("R5 no ack while busy", k, 0);
        bstop;
        wc(BUSY + 200);
        rd_seq(11'h5F3, 1, "R3 random read");

        // R4 page write wrapping inside the page
        wr_txn(11'h12E, '{8'h11, 8'h22, 8'h33, 8'h44}, 1'b0, "R4");
        wc(BUSY + 200);
        rd_seq(11'h120, 2, "R4 wrapped bytes");
        rd_seq(11'h12E, 1, "R4 page start");

        // R9 current-address read continues after 0x12E
        bstart;
        send(devb(11'h12F, 1'b1), 1'b0, k); chk("R9 device ack", k, 1);
        recv(1'b0, v); chk("R9 current address", v, exp_mem[11'h12F]);
        bstop;

        // R8 sequential read across the top of the space
        wr_txn(11'h7FF, '{8'h5A}, 1'b0, "R8");
        wc(BUSY + 200);
        wr_txn(11'h000, '{8'hC3}, 1'b0, "R8");
        wc(BUSY + 200);
        rd_seq(11'h7FF, 2, "R8 wrap read");

        // R6 write lock
        wr_lock = 1'b1;
        wr_txn(11'h5F3, '{8'h00}, 1'b0, "R6");
        bstart;
        send(devb(11'h5F3, 1'b0), 1'b0, k); chk("R6 no busy after locked write", k, 1);
        bstop;
        wr_lock = 1'b0;
        rd_seq(11'h5F3, 1, "R6 array unchanged");

        // R7 low supply
        supply_ok = 1'b0;
        wr_txn(11'h5F3, '{8'h3C}, 1'b0, "R7");
        supply_ok = 1'b1;
        bstart;
        send(devb(11'h5F3, 1'b0), 1'b0, k); chk("R7 no busy after low supply", k, 1);
        bstop;
        rd_seq(11'h5F3, 1, "R7 array unchanged");

        // R10 short SDA pulse while SCL high
        wr_txn(11'h5F3, '{8'hB5}, 1'b1, "R10");
        wc(BUSY + 200);
        rd_seq(11'h5F3, 1, "R10 glitch ignored");

        chk("R11 pull steady while SCL high", viol, 0);
    endtask

    initial begin
        fork
            run_all;
            begin
                wc(190000);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule